// File: doc/BRIEF.md
# Two-Step Refresh Watchdog Timer

This block is a 16-bit watchdog counter. Software starts it and keeps it alive with the same two-step sequence. First an arm strobe sets an arm flag. Then a confirm strobe must arrive while that flag is still set. The arm flag clears itself after a fixed number of machine-cycle ticks, so a confirm that arrives too late does nothing. The first accepted sequence starts the counter. After that the counter cannot be stopped; only reset stops it.

Each accepted sequence loads the counter's high byte from the lower seven bits of a reload register and clears its low byte. Bit 7 of the reload register puts an extra divider into the count path. The counter advances once every `BASE_DIV` clocks, or once every `BASE_DIV*EXT_DIV` clocks when the extra divider is selected. While the counter holds the terminal value `TERM`, the reset request output is high. It drops as soon as the counter moves on. The time to timeout is therefore (`TERM` − start count) × step period. The status bit that software reads at the confirm position reports whether the watchdog has been started.

Top module: `wdog_two_step`

## Requirements
- R1: After reset the counter is 0, the watchdog is not started, the reload register reads 0x00, and `status_o` and `rst_req_o` are 0.
- R2: Before the first accepted sequence, the counter does not advance and `rst_req_o` stays 0, whatever ticks arrive.
- R3: A confirm strobe is accepted when the arm flag is set. The arm flag is set if at most WIN−1 ticks have arrived in the cycles after the arm strobe and before the confirm strobe. On acceptance the counter becomes {1'b0, reload[6:0], 8'h00} on the next clock and `status_o` reads 1.
- R4: A confirm strobe has no effect in two cases: when no arm strobe preceded it, or when WIN ticks have arrived since the arm strobe. The arm flag has cleared by then.
- R5: An accepted confirm clears the arm flag. A further confirm with no new arm strobe does not reload the counter.
- R6: Once started, the counter advances by one every BASE_DIV clocks when reload bit 7 is 0. It advances every BASE_DIV*EXT_DIV clocks when reload bit 7 is 1. The divider restarts on each accepted confirm.
- R7: `rst_req_o` is 1 exactly while the started counter equals TERM (0x7FFC). It rises (TERM − start) step periods after the accepting clock and stays high for one step period.
- R8: Once started, `status_o` stays 1 and the counter keeps running until reset. Later accepted sequences only reload it.
- R9: The reload register reads back the last value written. A write does not change the running count until the next accepted confirm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-clock pulse per machine cycle; times the arm window |
| arm_set_i | input | 1 | Write strobe setting the arm flag |
| confirm_set_i | input | 1 | Write strobe setting the confirm flag |
| rel_we_i | input | 1 | Reload register write strobe |
| rel_wdata_i | input | 8 | Reload write data: bit 7 prescale select, bits 6:0 high-byte reload |
| rel_rdata_o | output | 8 | Reload register readback |
| status_o | output | 1 | Started status, read at the confirm bit position |
| rst_req_o | output | 1 | Reset request, high while the count sits at TERM |

## Verification
The bench builds the block with BASE_DIV=2 and EXT_DIV=4, and keeps WIN=12 and TERM=0x7FFC. With these values a full-range timeout from reload 0 takes 65528 clocks, so it fits in one run. The prescaled path is also exercised, and the bench sees a reload that lands in the middle of a count. The arm window keeps its real length, so both the eleventh and the twelfth tick are tried.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned REL_W     = 8;
  localparam int unsigned REL_PSEL  = 7;   // prescale select bit of reload
  localparam int unsigned REL_HB_W  = 7;   // reload bits feeding the high byte
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int unsigned BASE_DIV = 24,
  parameter int unsigned EXT_DIV  = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  input  logic ext_sel_i,
  output logic step_o
);
  localparam int unsigned BW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;

  logic [BW-1:0] base_q;
  logic          base_wrap;

  assign base_wrap = run_i && (base_q == BW'(BASE_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        base_q <= '0;
    else if (clr_i)     base_q <= '0;
    else if (base_wrap) base_q <= '0;
    else if (run_i)     base_q <= base_q + 1'b1;
  end

  generate
    if (EXT_DIV > 1) begin : g_ext
      localparam int unsigned EW = $clog2(EXT_DIV);
      logic [EW-1:0] ext_q;
      logic          ext_last;
      assign ext_last = (ext_q == EW'(EXT_DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                      ext_q <= '0;
        else if (clr_i)                   ext_q <= '0;
        else if (base_wrap && ext_sel_i)  ext_q <= ext_last ? '0 : ext_q + 1'b1;
      end
      assign step_o = base_wrap && (!ext_sel_i || ext_last);
    end else begin : g_noext
      logic unused_sel;
      assign unused_sel = ext_sel_i;
      assign step_o = base_wrap;
    end
  endgenerate
endmodule

// File: rtl/wdog_arm_window.sv
module wdog_arm_window #(
  parameter int unsigned WIN = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_set_i,
  input  logic consume_i,
  input  logic tick_i,
  output logic armed_o
);
  localparam int unsigned TW = (WIN > 1) ? $clog2(WIN) : 1;

  logic          armed_q;
  logic [TW-1:0] tcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      tcnt_q  <= '0;
    end else if (arm_set_i) begin
      armed_q <= 1'b1;
      tcnt_q  <= '0;
    end else if (consume_i) begin
      armed_q <= 1'b0;
      tcnt_q  <= '0;
    end else if (armed_q && tick_i) begin
      if (tcnt_q == TW'(WIN - 1)) begin
        armed_q <= 1'b0;
        tcnt_q  <= '0;
      end else begin
        tcnt_q  <= tcnt_q + 1'b1;
      end
    end
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned      CNT_W = 16,
  parameter logic [CNT_W-1:0] TERM  = 16'h7FFC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] count_o,
  output logic             at_term_o
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (load_i) count_q <= load_val_i;
    else if (step_i) count_q <= count_q + 1'b1;
  end

  assign count_o   = count_q;
  assign at_term_o = (count_q == TERM);
endmodule

// File: rtl/wdog_two_step.sv
module wdog_two_step
  import wdog_pkg::*;
#(
  parameter int unsigned      CNT_W    = 16,
  parameter int unsigned      BASE_DIV = 24,
  parameter int unsigned      EXT_DIV  = 16,
  parameter int unsigned      WIN      = 12,
  parameter logic [CNT_W-1:0] TERM     = 16'h7FFC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             arm_set_i,
  input  logic             confirm_set_i,
  input  logic             rel_we_i,
  input  logic [REL_W-1:0] rel_wdata_i,
  output logic [REL_W-1:0] rel_rdata_o,
  output logic             status_o,
  output logic             rst_req_o
);
  localparam int unsigned HB_W  = CNT_W / 2;
  localparam int unsigned PAD_W = HB_W - REL_HB_W;

  logic [REL_W-1:0] rel_q;
  logic             started_q;
  logic             armed;
  logic             refresh;
  logic             step;
  logic             at_term;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] load_val;

  assign refresh  = armed && confirm_set_i;
  assign load_val = {{PAD_W{1'b0}}, rel_q[REL_HB_W-1:0], {HB_W{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rel_q <= '0;
    else if (rel_we_i) rel_q <= rel_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      started_q <= 1'b0;
    else if (refresh) started_q <= 1'b1;
  end

  wdog_arm_window #(.WIN(WIN)) u_arm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_set_i (arm_set_i),
    .consume_i (refresh),
    .tick_i    (tick_i),
    .armed_o   (armed)
  );

  wdog_prescale #(.BASE_DIV(BASE_DIV), .EXT_DIV(EXT_DIV)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (started_q),
    .clr_i     (refresh),
    .ext_sel_i (rel_q[REL_PSEL]),
    .step_o    (step)
  );

  wdog_counter #(.CNT_W(CNT_W), .TERM(TERM)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (refresh),
    .load_val_i (load_val),
    .step_i     (step),
    .count_o    (count_q),
    .at_term_o  (at_term)
  );

  assign rel_rdata_o = rel_q;
  assign status_o    = started_q;
  assign rst_req_o   = started_q && at_term;
endmodule

// File: rtl/wdog_two_step_chk.sv
module wdog_two_step_chk #(
  parameter int unsigned      CNT_W = 16,
  parameter logic [CNT_W-1:0] TERM  = 16'h7FFC
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             arm_set_i,
  input logic             armed,
  input logic             refresh,
  input logic [CNT_W-1:0] count_q,
  input logic [7:0]       rel_q,
  input logic             started_q,
  input logic             rst_req_o
);
  localparam int unsigned HB_W = CNT_W / 2;

  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started_q |-> (count_q == '0 && !rst_req_o));

  p_refresh_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh |=> (count_q[HB_W-1:0] == '0 &&
                 count_q[CNT_W-1:HB_W] == HB_W'($past(rel_q[6:0])) && started_q));

  p_arm_consumed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refresh && !arm_set_i) |=> !armed);

  p_step_by_one_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && !refresh) |=>
      (count_q == $past(count_q) || count_q == CNT_W'($past(count_q) + 1'b1)));

  p_req_at_term_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (started_q && count_q == TERM));

  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |=> started_q);
endmodule

bind wdog_two_step wdog_two_step_chk #(.CNT_W(CNT_W), .TERM(TERM)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .arm_set_i (arm_set_i),
  .armed     (armed),
  .refresh   (refresh),
  .count_q   (count_q),
  .rel_q     (rel_q),
  .started_q (started_q),
  .rst_req_o (rst_req_o)
);

// File: tb/wdog_two_step_test.sv
`timescale 1ns/1ps
module wdog_two_step_test;
  localparam int BD   = 2;
  localparam int ED   = 4;
  localparam int WIN  = 12;
  localparam int TERM = 32'h7FFC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, arm = 1'b0, conf = 1'b0, rel_we = 1'b0;
  logic [7:0] rel_wdata = 8'h00;
  logic [7:0] rel_rdata;
  logic status, rst_req;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_two_step #(.CNT_W(16), .BASE_DIV(BD), .EXT_DIV(ED), .WIN(WIN), .TERM(16'h7FFC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .arm_set_i(arm),
    .confirm_set_i(conf), .rel_we_i(rel_we), .rel_wdata_i(rel_wdata),
    .rel_rdata_o(rel_rdata), .status_o(status), .rst_req_o(rst_req)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int  m_count, m_base, m_ext, m_ticks;
  bit  m_started, m_arm;
  int  m_rel;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_count = 0; m_base = 0; m_ext = 0; m_ticks = 0;
      m_started = 0; m_arm = 0; m_rel = 0;
    end else begin
      bit acc;
      acc = m_arm && conf;
      if (acc) begin
        m_count = (m_rel % 128) * 256; m_base = 0; m_ext = 0; m_started = 1;
      end else if (m_started) begin
        m_base++;
        if (m_base == BD) begin
          m_base = 0;
          if (m_rel >= 128) begin
            m_ext++;
            if (m_ext == ED) begin m_ext = 0; m_count = (m_count + 1) % 65536; end
          end else m_count = (m_count + 1) % 65536;
        end
      end
      if (arm) begin m_arm = 1; m_ticks = 0; end
      else if (acc) m_arm = 0;
      else if (m_arm && tick) begin
        if (m_ticks == WIN - 1) m_arm = 0; else m_ticks++;
      end
      if (rel_we) m_rel = rel_wdata;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    check(rst_req == (m_started && m_count == TERM), "R7 per-cycle request", rst_req, m_started && m_count == TERM);
    check(status == m_started, "R8 per-cycle status", status, m_started);
    check(rel_rdata == m_rel, "R9 per-cycle readback", rel_rdata, m_rel);
  end

  task automatic pulse_tick();
    tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
  endtask

  task automatic write_rel(input logic [7:0] v);
    rel_we = 1'b1; rel_wdata = v; @(negedge clk); rel_we = 1'b0;
  endtask

  task automatic sequence_try(input int nticks, input bit do_arm);
    if (do_arm) begin arm = 1'b1; @(negedge clk); arm = 1'b0; end
    for (int i = 0; i < nticks; i++) pulse_tick();
    conf = 1'b1; @(negedge clk); conf = 1'b0;
  endtask

  // cycles from the accepting edge until rst_req_o is seen high
  task automatic measure(input int poke_conf, input int poke_rel, input logic [7:0] pv, output int k);
    k = 0;
    while (!rst_req && k < 150000) begin
      conf = (k == poke_conf);
      rel_we = (k == poke_rel);
      rel_wdata = pv;
      @(negedge clk);
      k++;
    end
    conf = 1'b0; rel_we = 1'b0;
  endtask

  task automatic req_width(output int w);
    w = 0;
    while (rst_req && w < 1000) begin @(negedge clk); w++; end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R7 run hung actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int k, w;
    repeat (3) @(negedge clk);
    check(rel_rdata == 8'h00 && status == 1'b0 && rst_req == 1'b0, "R1 outputs in reset", {rel_rdata, status, rst_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rel_rdata == 8'h00 && status == 1'b0 && rst_req == 1'b0, "R1 after reset", {rel_rdata, status, rst_req}, 0);

    for (int i = 0; i < 50; i++) pulse_tick();
    check(status == 1'b0 && rst_req == 1'b0, "R2 idle with ticks", {status, rst_req}, 0);

    write_rel(8'h7F);
    @(negedge clk);
    check(rel_rdata == 8'h7F, "R9 reload readback", rel_rdata, 8'h7F);

    sequence_try(0, 1'b0);
    @(negedge clk);
    check(status == 1'b0, "R4 confirm without arm", status, 0);

    sequence_try(WIN, 1'b1);
    @(negedge clk);
    check(status == 1'b0, "R4 confirm after window", status, 0);
    check(rst_req == 1'b0, "R2 still idle", rst_req, 0);

    // accepted on the last legal tick count
    arm = 1'b1; @(negedge clk); arm = 1'b0;
    for (int i = 0; i < WIN - 1; i++) pulse_tick();
    conf = 1'b1; @(negedge clk); conf = 1'b0;
    check(status == 1'b1, "R3 accepted confirm sets status", status, 1);
    // stray confirm at 50 (R5) and reload write at 80 (R9) must not move timeout
    measure(50, 80, 8'h00, k);
    check(k == (TERM - 32'h7F00) * BD, "R5 R9 timeout from 0x7F00 unchanged", k, (TERM - 32'h7F00) * BD);
    req_width(w);
    check(w == BD, "R7 request width", w, BD);
    check(status == 1'b1, "R8 status sticky after request", status, 1);
    check(rel_rdata == 8'h00, "R9 readback after running write", rel_rdata, 0);

    // full range from reload 0
    sequence_try(0, 1'b1);
    measure(-1, -1, 8'h00, k);
    check(k == TERM * BD, "R6 full range timeout", k, TERM * BD);
    req_width(w);
    check(w == BD, "R7 request width full range", w, BD);

    // prescaled, reloaded mid-count so low byte must be cleared
    write_rel(8'hFF);
    repeat (37) @(negedge clk);
    check(status == 1'b1, "R8 still running", status, 1);
    sequence_try(3, 1'b1);
    measure(-1, -1, 8'h00, k);
    check(k == (TERM - 32'h7F00) * BD * ED, "R6 R3 prescaled timeout", k, (TERM - 32'h7F00) * BD * ED);
    req_width(w);
    check(w == BD * ED, "R7 prescaled request width", w, BD * ED);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule